// File: doc/BRIEF.md
# Four-Line Level Interrupt Status and Enable Register

This block gathers four level-sensitive legacy interrupt lines into one 32-bit control word. The word holds a pending flag and an enable bit for each line. It also keeps several mask bits for bus-error events, request-priority bits for seven bus masters, and a ready-wait field. To software these extra bits are plain storage. The block drives one registered interrupt request toward a parent interrupt controller. That request is high while any line has both its pending flag and its enable bit set.

Each line is first passed through a synchronizer. While the synchronized line is high, its pending flag is set again on every clock. Writing a one to a pending flag acknowledges it. If the source still holds its level, the flag comes back on the next edge. Writes carry four byte strobes, so a halfword write can target the upper half of the word alone. A single halfword write of 0xF000 to the upper half acknowledges every line and disables every line at once.

Top module: `intx_irq_ctl`

## Requirements
- R1: After reset, the control word reads 0x00000000 and the interrupt request output is low.
- R2: Pending flag i sits at bit 28+i (line 0 at bit 28, line 3 at bit 31). It becomes 1 on the third rising edge after its input line goes high, because of a two-stage synchronizer. It stays 1 after the line falls, until it is acknowledged.
- R3: A write with byte strobe 3 set clears each pending flag whose data bit is 1 and leaves unchanged each flag whose data bit is 0. A write can never set a pending flag.
- R4: If a line is still high when its flag is acknowledged, the flag reads 1 again right after the acknowledging write.
- R5: Enable bit i sits at bit 22+i, and a value of 1 lets line i through. The request output equals the OR over all lines of (pending AND enable), taken one clock after those bits.
- R6: Byte strobe b (bit b of the strobe input) updates only bits 8b+7 down to 8b. Lanes whose strobe is clear keep their value.
- R7: Bits 27:26 (error masks), 21:16 (event masks), 14:8 (master priorities) and 3:0 (ready-wait field) read back exactly what was last written to them.
- R8: Bits 15 and 7:4 always read 0 and ignore writes.
- R9: Writing data 0xF0000000 with strobes 4'b1100 clears all four pending flags, the enables and the error masks, and leaves bits 15:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request for the current cycle |
| wrStrb | input | 4 | Byte-lane strobes; bit b selects bits 8b+7:8b |
| wrData | input | 32 | Write data |
| intLines | input | 4 | Level interrupt inputs, line 0 in bit 0 |
| rdData | output | 32 | Current control word |
| irqOut | output | 1 | Registered combined interrupt request |

## Verification
The bench aims at acknowledging a line whose source is still held high. A design that let the clear win over the set would drop the request while the source still asks for service. It also writes zeros to the pending field and writes while the pending flags are clear. A design that treated the field as ordinary storage would clear or set flags. Halfword and single-byte writes catch a design that ignores strobes and damages the priority or wait fields. The synchronizer latency and the one-cycle lag of the request output are checked on exact edges. An extra or missing register stage would therefore show up as an early or late flag.

// File: rtl/intx_irq_ctl_pkg.sv
package intx_irq_ctl_pkg;
  localparam int NUM_LINES   = 4;
  localparam int WORD_W      = 32;
  localparam int NUM_LANES   = WORD_W / 8;
  localparam int PEND_LSB    = 28;
  localparam int ENA_LSB     = 22;
  localparam int PEND_LANE   = PEND_LSB / 8;

  // Bits that hold storage written by the CPU (everything but pending and reserved)
  localparam logic [WORD_W-1:0] PEND_FIELD   = {{(WORD_W-PEND_LSB-NUM_LINES){1'b0}},
                                                {NUM_LINES{1'b1}}, {PEND_LSB{1'b0}}};
  localparam logic [WORD_W-1:0] RSVD_FIELD   = 32'h0000_80F0;
  localparam logic [WORD_W-1:0] STORE_FIELD  = ~(PEND_FIELD | RSVD_FIELD);

  typedef struct packed {
    logic [NUM_LANES-1:0] laneWr;
    logic [NUM_LINES-1:0] pendClr;
  } wr_strobe_t;
endpackage

// File: rtl/intx_wr_ctrl.sv
module intx_wr_ctrl
  import intx_irq_ctl_pkg::*;
(
  input  logic                 wrEn,
  input  logic [NUM_LANES-1:0] wrStrb,
  input  logic [WORD_W-1:0]    wrData,
  output wr_strobe_t           strobes
);
  logic pendLaneHit;

  assign pendLaneHit = wrEn && wrStrb[PEND_LANE];

  always_comb begin
    strobes.laneWr  = wrEn ? wrStrb : '0;
    strobes.pendClr = pendLaneHit ? wrData[PEND_LSB +: NUM_LINES] : '0;
  end
endmodule

// File: rtl/intx_datapath.sv
module intx_datapath
  import intx_irq_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  wr_strobe_t           strobes,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] intLines,
  output logic [WORD_W-1:0]    regWord,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_LINES-1:0] lineSync;
  logic [NUM_LINES-1:0] pendQ;
  logic [WORD_W-1:0]    storeQ;
  logic [NUM_LINES-1:0] enaBits;

  // Input synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= '0;
        else if (s == 0) syncPipe[s] <= intLines;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign lineSync = syncPipe[SYNC_STAGES-1];

  // Storage lanes
  genvar b;
  generate
    for (b = 0; b < NUM_LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) storeQ[8*b +: 8] <= '0;
        else if (strobes.laneWr[b])
          storeQ[8*b +: 8] <= wrData[8*b +: 8] & STORE_FIELD[8*b +: 8];
      end
    end
  endgenerate

  // Pending flags: a high synchronized level outranks an acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~strobes.pendClr) | lineSync;
  end

  assign enaBits = storeQ[ENA_LSB +: NUM_LINES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(pendQ & enaBits);
  end

  assign regWord = storeQ | {{(WORD_W-PEND_LSB-NUM_LINES){1'b0}}, pendQ, {PEND_LSB{1'b0}}};
endmodule

// File: rtl/intx_irq_ctl.sv
module intx_irq_ctl
  import intx_irq_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrStrb,
  input  logic [31:0] wrData,
  input  logic [3:0]  intLines,
  output logic [31:0] rdData,
  output logic        irqOut
);
  wr_strobe_t strobes;

  intx_wr_ctrl i_ctrl (
    .wrEn    (wrEn),
    .wrStrb  (wrStrb),
    .wrData  (wrData),
    .strobes (strobes)
  );

  intx_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .intLines (intLines),
    .regWord  (rdData),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/intx_irq_ctl_chk.sv
module intx_irq_ctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  wrStrb,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        irqOut
);
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15] == 1'b0) && (rdData[7:4] == 4'b0));

  p_irq_lag_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |($past(rdData[31:28]) & $past(rdData[25:22])));

  p_no_spont_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rdData[31:28]) & ~rdData[31:28] &
      ~(($past(wrEn) && $past(wrStrb[3])) ? $past(wrData[31:28]) : 4'b0)) == 4'b0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData[27:0]));

  p_lane0_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrStrb[0]) |=> $stable(rdData[7:0]));

  p_wait_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrStrb[0]) |=> rdData[3:0] == $past(wrData[3:0]));
endmodule

bind intx_irq_ctl intx_irq_ctl_chk i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrStrb (wrStrb),
  .wrData (wrData),
  .rdData (rdData),
  .irqOut (irqOut)
);

// File: tb/test_intx_irq_ctl.sv
module test_intx_irq_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrStrb = 4'b0;
  logic [31:0] wrData = 32'b0;
  logic [3:0]  intLines = 4'b0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] model;

  localparam logic [31:0] STORE_BITS = 32'h0FFF_7F0F;

  always #4 clk = ~clk;

  intx_irq_ctl i_intx_irq_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStrb(wrStrb), .wrData(wrData),
    .intLines(intLines), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] applyWrite(logic [31:0] old, logic [31:0] d, logic [3:0] s);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++)
      if (s[b]) r[8*b +: 8] = (d[8*b +: 8] & STORE_BITS[8*b +: 8]) | (old[8*b +: 8] & ~STORE_BITS[8*b +: 8]);
    if (s[3]) r[31:28] = old[31:28] & ~d[31:28];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrStrb = s;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; wrStrb = '0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    waitCycles(3);
    chk("R1 reset word", rdData, 32'h0);
    chk("R1 reset irq", {31'b0, irqOut}, 32'h0);
    @(negedge clk) rstN = 1'b1;
    waitCycles(1);

    // R7 / R8: full write, pending flags not settable
    doWrite(32'hFFFF_FFFF, 4'hF);
    chk("R7 R8 R3 full write", rdData, 32'h0FFF_7F0F);

    // R9: upper halfword 0xF000
    doWrite(32'hF000_0000, 4'b1100);
    chk("R9 halfword clear", rdData, 32'h0000_7F0F);

    // R6: single lane write
    doWrite(32'hAAAA_AAA5, 4'b0001);
    chk("R6 lane0 only", rdData, 32'h0000_7F05);

    // R5: enable line 1 (bit 23)
    doWrite(32'h0080_0000, 4'b0100);
    chk("R5 enable write", rdData, 32'h0080_7F05);

    // R2: latency of line 1
    @(negedge clk) intLines = 4'b0010;
    waitCycles(2);
    chk("R2 not yet pending", {31'b0, rdData[29]}, 32'h0);
    waitCycles(1);
    chk("R2 pending on third edge", {31'b0, rdData[29]}, 32'h1);
    chk("R5 irq lags pending", {31'b0, irqOut}, 32'h0);
    waitCycles(1);
    chk("R5 irq asserted", {31'b0, irqOut}, 32'h1);
    intLines = 4'b0000;
    waitCycles(4);
    chk("R2 flag held after line drops", {31'b0, rdData[29]}, 32'h1);

    // R3: writing zero leaves flag
    doWrite(32'h0000_0000, 4'b1000);
    chk("R3 zero write keeps flag", {31'b0, rdData[29]}, 32'h1);
    doWrite(32'h2000_0000, 4'b1000);
    chk("R3 acknowledge clears", {31'b0, rdData[29]}, 32'h0);
    chk("R5 irq still high one cycle", {31'b0, irqOut}, 32'h1);
    waitCycles(1);
    chk("R5 irq drops", {31'b0, irqOut}, 32'h0);

    // R5 gating and R4 re-set: line 0 not enabled
    @(negedge clk) intLines = 4'b0001;
    waitCycles(4);
    chk("R2 line0 pending", rdData, 32'h1080_7F05);
    chk("R5 disabled line no irq", {31'b0, irqOut}, 32'h0);
    doWrite(32'h1000_0000, 4'b1000);
    chk("R4 held level re-sets", {31'b0, rdData[28]}, 32'h1);
    intLines = 4'b0000;
    waitCycles(4);
    doWrite(32'h1000_0000, 4'b1000);
    chk("R3 clear after line drop", rdData, 32'h0080_7F05);

    // R9 with all lines pending and enabled
    doWrite(32'h03C0_0000, 4'b1100);
    @(negedge clk) intLines = 4'b1111;
    waitCycles(1);
    intLines = 4'b0000;
    waitCycles(4);
    chk("R2 all pending", rdData[31:28], 4'hF);
    chk("R5 irq all", {31'b0, irqOut}, 32'h1);
    doWrite(32'hF000_0000, 4'b1100);
    chk("R9 clears flags and enables", rdData, 32'h0000_7F05);
    waitCycles(1);
    chk("R9 irq off", {31'b0, irqOut}, 32'h0);

    // Random writes, lines idle (R6 R7 R8)
    model = rdData;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] d;
      logic [3:0] s;
      d = $urandom();
      s = 4'($urandom());
      doWrite(d, s);
      model = applyWrite(model, d, s);
      chk("R6 R7 R8 random write", rdData, model);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule